// File: doc/BRIEF.md
# Bitwise Logic Operation Unit

This unit sits in the execute stage of an instruction pipeline that uses 64-bit instruction words. It recognises the bitwise-logic instruction by its opcode. It combines a 32-bit register value with a 32-bit immediate carried in the instruction word. Before the combine, either operand may be complemented, each under its own flag. A 2-bit selector then picks AND, OR, XOR or a mode that forwards operand B unchanged.

The caller presents the instruction word, the value of the source register named in the instruction and a valid strobe. One clock later the unit returns the result, the destination register index, a result-valid pulse and a write enable for the register file. Register index 255 is a hardwired zero register. As a source it reads as zero, whatever value arrives on the operand port. As a destination it is never written.

Top module: `bitop_exec_unit`

## Requirements
- R1: The instruction is recognised only when bits 63:58 equal 000001. An unrecognised instruction with a valid strobe gives out_wr_en = 0 and out_result = 0.
- R2: The selector at bits 54:53 picks the function: 0 gives A AND B, 1 gives A OR B, 2 gives A XOR B.
- R3: Selector value 3 forwards operand B, after its optional inversion. Operand A and its inversion flag have no effect on the result.
- R4: When bit 55 is set, operand A is complemented bit by bit before the function is applied.
- R5: When bit 56 is set, operand B is complemented bit by bit before the function is applied.
- R6: Operand B is the 32-bit immediate in bits 51:20, with bit 20 as its least significant bit.
- R7: The source index is bits 15:8. When it equals 255, operand A is zero and the in_opa port is ignored.
- R8: out_dst carries bits 7:0 of the accepted instruction. When it equals 255, out_wr_en stays 0.
- R9: The result, destination, out_valid and out_wr_en appear exactly one clock after a valid input. out_valid is high for one cycle per valid input. Cycles without a valid input give out_valid = 0 and out_wr_en = 0, and out_result and out_dst keep their previous values.
- R10: While rst_n is low at a clock edge, every output is cleared to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction and operand are valid this cycle |
| in_instr | input | 64 | Instruction word |
| in_opa | input | 32 | Value of the source register named in bits 15:8 |
| out_valid | output | 1 | Result-valid pulse, one clock after in_valid |
| out_wr_en | output | 1 | Write enable for the destination register |
| out_dst | output | 8 | Destination register index |
| out_result | output | 32 | Logic result |

## Verification
Every result of this unit is due on the first rising edge after the input is presented. The bench drives inputs on a falling edge and removes the strobe on the next falling edge. By then the one register stage has captured the values, so it reads all four outputs at that falling edge. One cycle further on, it reads the outputs again to confirm that the valid pulse has ended and that the result and destination are held. Back-to-back inputs are checked one falling edge apart, each against the instruction issued one cycle earlier.

// File: rtl/bitop_pkg.sv
// Package: bitop_pkg
// Shared widths, field positions and types for the bitwise logic unit.
// Assumes a 64-bit instruction word with fixed field positions.
package bitop_pkg;

    localparam int INSTR_W   = 64;
    localparam int DATA_W    = 32;
    localparam int IDX_W     = 8;

    localparam int OPC_W     = 6;
    localparam int OPC_LSB   = 58;
    localparam logic [OPC_W-1:0] OPC_LOGIC = 6'b000001;

    localparam int FN_LSB    = 53;
    localparam int INVA_BIT  = 55;
    localparam int INVB_BIT  = 56;
    localparam int IMM_LSB   = 20;
    localparam int SRC_LSB   = 8;
    localparam int DST_LSB   = 0;

    typedef enum logic [1:0] {
        FN_AND   = 2'd0,
        FN_OR    = 2'd1,
        FN_XOR   = 2'd2,
        FN_PASSB = 2'd3
    } logic_fn_e;

    typedef struct packed {
        logic              hit;
        logic_fn_e         fn;
        logic              inv_a;
        logic              inv_b;
        logic [DATA_W-1:0] imm;
        logic [IDX_W-1:0]  src;
        logic [IDX_W-1:0]  dst;
    } bitop_dec_t;

endpackage

// File: rtl/bitop_decode.sv
// Module: bitop_decode
// Splits an instruction word into the fields the logic unit needs and
// flags whether the opcode names the bitwise-logic instruction.
// Assumes the field positions given in bitop_pkg. Purely combinational.
module bitop_decode
    import bitop_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output bitop_dec_t         dec
);

    // Field extraction from fixed bit positions
    always_comb begin
        dec.hit   = (instr[OPC_LSB +: OPC_W] == OPC_LOGIC);
        dec.fn    = logic_fn_e'(instr[FN_LSB +: 2]);
        dec.inv_a = instr[INVA_BIT];
        dec.inv_b = instr[INVB_BIT];
        dec.imm   = instr[IMM_LSB +: DATA_W];
        dec.src   = instr[SRC_LSB +: IDX_W];
        dec.dst   = instr[DST_LSB +: IDX_W];
    end

endmodule

// File: rtl/bitop_operand.sv
// Module: bitop_operand
// Conditions one operand: forces it to zero when it comes from the zero
// register, then optionally complements every bit.
// Assumes zeroing happens before inversion. Purely combinational.
module bitop_operand #(
    parameter int W = 32
) (
    input  logic [W-1:0] raw,
    input  logic         force_zero,
    input  logic         invert,
    output logic [W-1:0] cooked
);

    logic [W-1:0] base;

    // Zero-register substitution followed by optional complement
    always_comb begin
        base   = force_zero ? '0 : raw;
        cooked = invert ? ~base : base;
    end

endmodule

// File: rtl/bitop_combine.sv
// Module: bitop_combine
// Applies the selected two-input bitwise function to conditioned operands.
// Assumes operands have already been inverted as requested. Combinational.
module bitop_combine
    import bitop_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic_fn_e    fn,
    output logic [W-1:0] y
);

    // Function select
    always_comb begin
        unique case (fn)
            FN_AND:   y = a & b;
            FN_OR:    y = a | b;
            FN_XOR:   y = a ^ b;
            FN_PASSB: y = b;
            default:  y = b;
        endcase
    end

endmodule

// File: rtl/bitop_exec_unit.sv
// Module: bitop_exec_unit
// Single-cycle execute unit for the bitwise-logic instruction. It decodes the
// word, conditions the register operand A and the immediate operand B, applies
// the selected function and registers the result with its destination index.
// Assumes in_opa already holds the register named by bits 15:8. Index 255 is a
// zero register: it reads as zero and is never written.
module bitop_exec_unit
    import bitop_pkg::*;
#(
    parameter int P_INSTR_W = INSTR_W,
    parameter int P_DATA_W  = DATA_W,
    parameter int P_IDX_W   = IDX_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [P_INSTR_W-1:0] in_instr,
    input  logic [P_DATA_W-1:0]  in_opa,
    output logic                 out_valid,
    output logic                 out_wr_en,
    output logic [P_IDX_W-1:0]   out_dst,
    output logic [P_DATA_W-1:0]  out_result
);

    localparam logic [P_IDX_W-1:0] ZERO_REG = {P_IDX_W{1'b1}};

    bitop_dec_t          dec;
    logic                src_is_zero;
    logic                dst_is_zero;
    logic [P_DATA_W-1:0] op_a;
    logic [P_DATA_W-1:0] op_b;
    logic [P_DATA_W-1:0] fn_y;
    logic [P_DATA_W-1:0] next_result;

    bitop_decode u_decode (
        .instr (in_instr),
        .dec   (dec)
    );

    // Zero-register detection for source and destination
    always_comb begin
        src_is_zero = (dec.src == ZERO_REG);
        dst_is_zero = (dec.dst == ZERO_REG);
    end

    bitop_operand #(.W(P_DATA_W)) u_opa (
        .raw        (in_opa),
        .force_zero (src_is_zero),
        .invert     (dec.inv_a),
        .cooked     (op_a)
    );

    bitop_operand #(.W(P_DATA_W)) u_opb (
        .raw        (dec.imm),
        .force_zero (1'b0),
        .invert     (dec.inv_b),
        .cooked     (op_b)
    );

    bitop_combine #(.W(P_DATA_W)) u_combine (
        .a  (op_a),
        .b  (op_b),
        .fn (dec.fn),
        .y  (fn_y)
    );

    // Unrecognised instructions produce a zero result
    always_comb begin
        next_result = dec.hit ? fn_y : '0;
    end

    // Output stage: one register between inputs and all outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_wr_en  <= 1'b0;
            out_dst    <= '0;
            out_result <= '0;
        end else begin
            out_valid <= in_valid;
            out_wr_en <= in_valid && dec.hit && !dst_is_zero;
            if (in_valid) begin
                out_dst    <= dec.dst;
                out_result <= next_result;
            end
        end
    end

endmodule

// File: rtl/bitop_exec_unit_chk.sv
// Module: bitop_exec_unit_chk
// Protocol checker for bitop_exec_unit, attached by bind. It relates the
// outputs to the inputs of the previous cycle. It assumes the field positions
// of bitop_pkg.
module bitop_exec_unit_chk
    import bitop_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [INSTR_W-1:0] in_instr,
    input logic [DATA_W-1:0]  in_opa,
    input logic               out_valid,
    input logic               out_wr_en,
    input logic [IDX_W-1:0]   out_dst,
    input logic [DATA_W-1:0]  out_result
);

    a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r9_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && !out_wr_en);

    a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_result) && $stable(out_dst));

    a_r1_no_write_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (in_instr[63:58] != 6'b000001) |=> !out_wr_en && out_result == '0);

    a_r8_dest_field: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_dst == $past(in_instr[7:0]));

    a_r8_zero_dest_never_written: assert property (@(posedge clk) disable iff (!rst_n)
        out_wr_en |-> out_dst != 8'hFF && out_valid);

    a_r3_passb_plain: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_instr[63:58] == 6'b000001 && in_instr[54:53] == 2'd3
        && !in_instr[56] |=> out_result == $past(in_instr[51:20]));

    a_r7_zero_src_and: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_instr[63:58] == 6'b000001 && in_instr[54:53] == 2'd0
        && !in_instr[55] && in_instr[15:8] == 8'hFF |=> out_result == '0);

    a_r10_reset_clears: assert property (@(posedge clk)
        !rst_n |=> !out_valid && !out_wr_en && out_result == '0 && out_dst == '0);

endmodule

bind bitop_exec_unit bitop_exec_unit_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_instr   (in_instr),
    .in_opa     (in_opa),
    .out_valid  (out_valid),
    .out_wr_en  (out_wr_en),
    .out_dst    (out_dst),
    .out_result (out_result)
);

// File: tb/bitop_exec_unit_bench.sv
// Bench for bitop_exec_unit: a vector table walked by one loop, then
// directed tests for reset, idle hold and back-to-back issue.
module bitop_exec_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_instr = '0;
    logic [31:0] in_opa = '0;
    logic        out_valid;
    logic        out_wr_en;
    logic [7:0]  out_dst;
    logic [31:0] out_result;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bitop_exec_unit u_bitop_exec_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_instr   (in_instr),
        .in_opa     (in_opa),
        .out_valid  (out_valid),
        .out_wr_en  (out_wr_en),
        .out_dst    (out_dst),
        .out_result (out_result)
    );

    localparam int NV = 14;
    // Columns: opcode, selector, invert A, invert B, immediate, source, dest, operand A, expected result, expected write
    localparam logic [5:0]  T_OPC [NV] = '{6'h01,6'h01,6'h01,6'h01,6'h01,6'h01,6'h01,
                                            6'h01,6'h01,6'h01,6'h01,6'h01,6'h02,6'h01};
    localparam logic [1:0]  T_FN  [NV] = '{0,1,2,3,0,1,2,3,3,1,0,2,0,0};
    localparam logic        T_IA  [NV] = '{0,0,0,0,1,0,1,0,1,0,1,0,0,0};
    localparam logic        T_IB  [NV] = '{0,0,0,0,0,1,1,1,0,0,0,0,0,0};
    localparam logic [31:0] T_IMM [NV] = '{32'h0FF0FF00, 32'h12340000, 32'h0F0F0F0F, 32'hCAFEF00D,
                                            32'h12345678, 32'hFFFFFF00, 32'h0000FFFF, 32'h00000001,
                                            32'h13579BDF, 32'h00000010, 32'h80000001, 32'h00000003,
                                            32'hFFFFFFFF, 32'h80000000};
    localparam logic [7:0]  T_SRC [NV] = '{3,4,5,6,7,8,9,10,11,255,255,12,13,14};
    localparam logic [7:0]  T_DST [NV] = '{5,6,7,8,9,10,11,12,13,14,15,255,16,0};
    localparam logic [31:0] T_A   [NV] = '{32'hF0F01234, 32'h000000FF, 32'hFFFF0000, 32'hDEADBEEF,
                                            32'hFFFF0000, 32'h00000000, 32'hAAAAAAAA, 32'h12345678,
                                            32'h00000001, 32'hFFFFFFFF, 32'h5A5A5A5A, 32'h00000001,
                                            32'hFFFFFFFF, 32'hFFFFFFFF};
    localparam logic [31:0] T_EXP [NV] = '{32'h00F01200, 32'h123400FF, 32'hF0F00F0F, 32'hCAFEF00D,
                                            32'h00005678, 32'h000000FF, 32'hAAAA5555, 32'hFFFFFFFE,
                                            32'h13579BDF, 32'h00000010, 32'h80000001, 32'h00000002,
                                            32'h00000000, 32'h80000000};
    localparam logic        T_WE  [NV] = '{1,1,1,1,1,1,1,1,1,1,1,0,0,1};
    localparam string       T_TAG [NV] = '{"R2 and R6", "R2 or", "R2 xor", "R3 passb",
                                            "R4 inv_a", "R5 inv_b", "R4 R5 both", "R3 R5 passb inv",
                                            "R3 passb ignores inv_a", "R7 zero src", "R7 R4 zero src inv",
                                            "R8 dest 255", "R1 opcode miss", "R6 imm top bit"};

    function automatic logic [63:0] mk(logic [5:0] opc, logic [1:0] fn, logic ia, logic ib,
                                       logic [31:0] imm, logic [7:0] src, logic [7:0] dst);
        return {opc, 1'b0, ib, ia, fn, 1'b0, imm, 4'b0, src, dst};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic issue(logic [63:0] ins, logic [31:0] a);
        @(negedge clk);
        in_instr = ins;
        in_opa   = a;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        in_opa   = 32'h0BAD0BAD;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: outputs cleared while in reset
        chk("R10 out_valid", {31'b0, out_valid}, 32'h0);
        chk("R10 out_wr_en", {31'b0, out_wr_en}, 32'h0);
        chk("R10 out_result", out_result, 32'h0);
        chk("R10 out_dst", {24'b0, out_dst}, 32'h0);
        rst_n = 1'b1;

        // Table walk: R1..R9 per row
        for (int i = 0; i < NV; i++) begin
            issue(mk(T_OPC[i], T_FN[i], T_IA[i], T_IB[i], T_IMM[i], T_SRC[i], T_DST[i]), T_A[i]);
            chk({T_TAG[i], " result"}, out_result, T_EXP[i]);
            chk({T_TAG[i], " R8 dst"}, {24'b0, out_dst}, {24'b0, T_DST[i]});
            chk({T_TAG[i], " wr_en"}, {31'b0, out_wr_en}, {31'b0, T_WE[i]});
            chk({T_TAG[i], " R9 valid"}, {31'b0, out_valid}, 32'h1);
        end

        // R9: idle cycle drops valid and holds result and dest
        issue(mk(6'h01, 2'd2, 1'b0, 1'b0, 32'h00FF00FF, 8'd20, 8'd21), 32'h0F0F0F0F);
        chk("R9 xor result", out_result, 32'h0FF00FF0);
        @(negedge clk);
        chk("R9 valid pulse ends", {31'b0, out_valid}, 32'h0);
        chk("R9 wr_en pulse ends", {31'b0, out_wr_en}, 32'h0);
        chk("R9 result held", out_result, 32'h0FF00FF0);
        chk("R9 dst held", {24'b0, out_dst}, 32'd21);

        // R9: back-to-back issue, each output one cycle after its input
        @(negedge clk);
        in_valid = 1'b1;
        in_instr = mk(6'h01, 2'd1, 1'b0, 1'b0, 32'h00000F00, 8'd1, 8'd30);
        in_opa   = 32'h000000F0;
        @(negedge clk);
        chk("R9 b2b first", out_result, 32'h00000FF0);
        chk("R9 b2b first dst", {24'b0, out_dst}, 32'd30);
        in_instr = mk(6'h01, 2'd0, 1'b1, 1'b1, 32'hFFFF0000, 8'd2, 8'd31);
        in_opa   = 32'hFF00FF00;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R9 b2b second", out_result, 32'h000000FF);
        chk("R9 b2b second valid", {31'b0, out_valid}, 32'h1);

        // R10: synchronous reset mid-run clears outputs
        issue(mk(6'h01, 2'd3, 1'b0, 1'b0, 32'h77777777, 8'd3, 8'd40), 32'h0);
        chk("R3 before reset", out_result, 32'h77777777);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R10 mid-run result", out_result, 32'h0);
        chk("R10 mid-run dst", {24'b0, out_dst}, 32'h0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule